// File: doc/BRIEF.md
# Threshold Reset Command Sequencer

This block watches a byte-level view of a two-wire serial bus and picks out one specific write command: the one that returns one of two programmable trip-threshold registers to its factory default. A byte deserializer upstream reports start and stop conditions and each received byte with a valid strobe. This block answers every byte it accepts with an acknowledge pulse. It tracks the three command bytes: the device identifier, the threshold selector and a zero data byte.

The command is only armed if the programming voltage is already present on the watchdog output pin when the start condition arrives. A stop after a complete, matching three-byte write does not finish the operation. It leaves the block waiting. The operation completes when the watchdog output pin is next pulled low. At that point the block emits a one-cycle reset strobe for the selected threshold together with a done pulse. Any mismatch, wrong byte count or new start drops the block back to idle without a strobe. Nothing in this block touches the general memory array.

Top module: `thr_reset_seq`

## Requirements
- R1: After reset, busy, ack, done and every bit of thr_clr are 0.
- R2: A start seen while vp_present is 0 arms nothing: busy stays 0, and no later byte of that transaction is acknowledged.
- R3: The first byte after an armed start is accepted only if it equals A0h. Any other value is not acknowledged, and the block returns to idle.
- R4: The second byte selects the threshold: 03h selects threshold 0 (thr_clr bit 0) and 0Bh selects threshold 1 (thr_clr bit 1). Any other value is not acknowledged and aborts to idle.
- R5: The third byte is accepted only if it equals 00h. Any other value is not acknowledged and aborts to idle.
- R6: Each accepted byte produces ack high for exactly the one cycle after the cycle in which rx_valid was high.
- R7: A stop after the three accepted bytes leaves busy at 1 and produces no done and no thr_clr strobe.
- R8: While waiting, a high-to-low change of wdo_lvl produces done and the selected thr_clr bit for one cycle, in the cycle after the low level is first sampled. The block is idle in that same cycle. A low-going wdo_lvl at any earlier stage of the command has no effect.
- R9: A fourth byte before the stop, or a stop before the third byte, aborts to idle without an acknowledge for the extra byte and without any later strobe.
- R10: A start while waiting for the pin cancels the pending operation. A later fall of wdo_lvl then produces no done.
- R11: thr_clr is nonzero only while done is high, and then has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_start | input | 1 | Start condition seen on the bus (one-cycle pulse) |
| bus_stop | input | 1 | Stop condition seen on the bus (one-cycle pulse) |
| rx_valid | input | 1 | A received byte is present on rx_byte |
| rx_byte | input | 8 | Received byte value |
| vp_present | input | 1 | Programming voltage present on the watchdog output pin |
| wdo_lvl | input | 1 | Sampled level of the watchdog output pin |
| ack | output | 1 | Acknowledge for the previous byte |
| busy | output | 1 | A threshold reset command is in progress |
| thr_clr | output | 2 | Per-threshold reset strobe, one bit per threshold |
| done | output | 1 | Threshold reset operation completed |

## Verification
The hardest situation to reach from the ports is the gap between the stop and the pin fall. It can only be entered after a fully matching three-byte write with the voltage present at the start. Inside that gap, a new start or a stray pin edge changes the outcome. The bench reaches it with a generic transaction task that sweeps every value of each byte position while the other two positions are held at their valid values. Each clean run ends with a pin fall. Dedicated sequences then stop inside the waiting state to inject a start, with and without the programming voltage, before the pin is pulled low.

// File: rtl/thr_seq_pkg.sv
package thr_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_ADR,
        ST_DAT,
        ST_STP,
        ST_WAIT
    } seq_st_e;

endpackage

// File: rtl/thr_fall_det.sv
module thr_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic fall_o
);

    logic prev_q;

    // Previous level reset to 0 so that release from reset never looks like a fall.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    assign fall_o = prev_q & ~lvl_i;

endmodule

// File: rtl/thr_cmd_decode.sv
module thr_cmd_decode #(
    parameter int                      BYTE_W    = 8,
    parameter int                      N_THR     = 2,
    parameter logic [BYTE_W-1:0]       DEV_ID    = 8'hA0,
    parameter logic [BYTE_W-1:0]       CLR_VAL   = 8'h00,
    parameter logic [N_THR*BYTE_W-1:0] SEL_CODES = {8'h0B, 8'h03},
    localparam int                     SEL_W     = (N_THR > 1) ? $clog2(N_THR) : 1
) (
    input  logic [BYTE_W-1:0] byte_i,
    output logic              dev_hit_o,
    output logic              dat_hit_o,
    output logic              sel_hit_o,
    output logic [SEL_W-1:0]  sel_idx_o
);

    logic [N_THR-1:0] code_match;

    for (genvar g = 0; g < N_THR; g++) begin : g_sel
        assign code_match[g] = (byte_i == SEL_CODES[g*BYTE_W +: BYTE_W]);
    end

    assign dev_hit_o = (byte_i == DEV_ID);
    assign dat_hit_o = (byte_i == CLR_VAL);
    assign sel_hit_o = |code_match;

    // Lowest index wins if two codes were ever configured equal.
    always_comb begin
        sel_idx_o = '0;
        for (int i = N_THR - 1; i >= 0; i--) begin
            if (code_match[i]) sel_idx_o = SEL_W'(i);
        end
    end

endmodule

// File: rtl/thr_reset_seq.sv
module thr_reset_seq
    import thr_seq_pkg::*;
#(
    parameter int                      BYTE_W    = 8,
    parameter int                      N_THR     = 2,
    parameter logic [BYTE_W-1:0]       DEV_ID    = 8'hA0,
    parameter logic [BYTE_W-1:0]       CLR_VAL   = 8'h00,
    parameter logic [N_THR*BYTE_W-1:0] SEL_CODES = {8'h0B, 8'h03}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              vp_present,
    input  logic              wdo_lvl,
    output logic              ack,
    output logic              busy,
    output logic [N_THR-1:0]  thr_clr,
    output logic              done
);

    localparam int SEL_W = (N_THR > 1) ? $clog2(N_THR) : 1;

    typedef struct packed {
        seq_st_e          st;
        logic [SEL_W-1:0] sel;
        logic             ack;
        logic             done;
        logic [N_THR-1:0] clr;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic             dev_hit, dat_hit, sel_hit;
    logic [SEL_W-1:0] sel_idx;
    logic             pin_fall;

    thr_cmd_decode #(
        .BYTE_W   (BYTE_W),
        .N_THR    (N_THR),
        .DEV_ID   (DEV_ID),
        .CLR_VAL  (CLR_VAL),
        .SEL_CODES(SEL_CODES)
    ) u_dec (
        .byte_i   (rx_byte),
        .dev_hit_o(dev_hit),
        .dat_hit_o(dat_hit),
        .sel_hit_o(sel_hit),
        .sel_idx_o(sel_idx)
    );

    thr_fall_det u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (wdo_lvl),
        .fall_o(pin_fall)
    );

    always_comb begin
        r_d      = r_q;
        r_d.ack  = 1'b0;
        r_d.done = 1'b0;
        r_d.clr  = '0;

        if (bus_start) begin
            // A start always restarts command tracking; it arms only with voltage present.
            r_d.st = vp_present ? ST_DEV : ST_IDLE;
        end else begin
            unique case (r_q.st)
                ST_IDLE: ;
                ST_DEV: begin
                    if (bus_stop) r_d.st = ST_IDLE;
                    else if (rx_valid) begin
                        if (dev_hit) begin
                            r_d.ack = 1'b1;
                            r_d.st  = ST_ADR;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                ST_ADR: begin
                    if (bus_stop) r_d.st = ST_IDLE;
                    else if (rx_valid) begin
                        if (sel_hit) begin
                            r_d.ack = 1'b1;
                            r_d.sel = sel_idx;
                            r_d.st  = ST_DAT;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                ST_DAT: begin
                    if (bus_stop) r_d.st = ST_IDLE;
                    else if (rx_valid) begin
                        if (dat_hit) begin
                            r_d.ack = 1'b1;
                            r_d.st  = ST_STP;
                        end else begin
                            r_d.st = ST_IDLE;
                        end
                    end
                end
                ST_STP: begin
                    if (bus_stop)      r_d.st = ST_WAIT;
                    else if (rx_valid) r_d.st = ST_IDLE;
                end
                ST_WAIT: begin
                    if (pin_fall) begin
                        r_d.done = 1'b1;
                        for (int i = 0; i < N_THR; i++) begin
                            if (r_q.sel == SEL_W'(i)) r_d.clr[i] = 1'b1;
                        end
                        r_d.st = ST_IDLE;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.sel  <= '0;
            r_q.ack  <= 1'b0;
            r_q.done <= 1'b0;
            r_q.clr  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ack     = r_q.ack;
    assign done    = r_q.done;
    assign thr_clr = r_q.clr;
    assign busy    = (r_q.st != ST_IDLE);

endmodule

// File: rtl/thr_reset_seq_chk.sv
module thr_reset_seq_chk #(
    parameter int N_THR = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_start,
    input logic             rx_valid,
    input logic             vp_present,
    input logic             ack,
    input logic             busy,
    input logic [N_THR-1:0] thr_clr,
    input logic             done
);

    // R2
    unarmed_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && !vp_present) |=> !busy);

    // R3
    idle_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !bus_start) |=> !ack);

    // R6
    ack_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(rx_valid));

    // R8
    done_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R11
    strobe_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_clr != '0) |-> done);

    // R11
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($countones(thr_clr) == 1));

endmodule

bind thr_reset_seq thr_reset_seq_chk #(.N_THR(N_THR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_start (bus_start),
    .rx_valid  (rx_valid),
    .vp_present(vp_present),
    .ack       (ack),
    .busy      (busy),
    .thr_clr   (thr_clr),
    .done      (done)
);

// File: tb/test_thr_reset_seq.sv
`timescale 1ns/1ps
module test_thr_reset_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_start = 1'b0;
    logic       bus_stop = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       vp_present = 1'b0;
    logic       wdo_lvl = 1'b1;
    logic       ack, busy, done;
    logic [1:0] thr_clr;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    thr_reset_seq i_thr_reset_seq (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .vp_present(vp_present),
        .wdo_lvl(wdo_lvl), .ack(ack), .busy(busy), .thr_clr(thr_clr), .done(done)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_start(input logic vp);
        @(negedge clk);
        bus_start  = 1'b1;
        vp_present = vp;
        @(negedge clk);
        bus_start = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk);
        bus_stop = 1'b1;
        @(negedge clk);
        bus_stop = 1'b0;
    endtask

    // Sends one byte; ack is registered, so it is checked at the following negedge.
    task automatic send(input logic [7:0] b, input bit exp_ack, input string tag);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        chk(ack == exp_ack, tag, ack, exp_ack);
    endtask

    // Pulls the pin low; done/strobe registered one edge after the low is first sampled.
    task automatic pin_fall(input bit exp_done, input logic [1:0] exp_clr, input string tag);
        @(negedge clk);
        wdo_lvl = 1'b0;
        @(negedge clk);
        chk(done == exp_done, {tag, " done"}, done, exp_done);
        chk(thr_clr == exp_clr, {tag, " thr_clr"}, thr_clr, exp_clr);
        @(negedge clk);
        chk(done == 1'b0 && thr_clr == 2'b00, {tag, " pulse width"}, {done, thr_clr}, 0);
        wdo_lvl = 1'b1;
        @(negedge clk);
    endtask

    // Full three-byte command with expected values computed from R3, R4, R5, R7, R8.
    task automatic run_cmd(input logic [7:0] dv, input logic [7:0] ad, input logic [7:0] dt);
        bit alive;
        bit hit;
        logic [1:0] exp_clr;
        do_start(1'b1);
        alive = 1'b1;
        hit   = (dv == 8'hA0);
        send(dv, alive && hit, "R3 device byte ack");
        alive = alive && hit;
        hit   = (ad == 8'h03) || (ad == 8'h0B);
        send(ad, alive && hit, "R4 selector byte ack");
        alive = alive && hit;
        hit   = (dt == 8'h00);
        send(dt, alive && hit, "R5 data byte ack");
        alive = alive && hit;
        do_stop();
        chk(busy == alive, "R7 busy after stop", busy, alive);
        chk(done == 1'b0 && thr_clr == 2'b00, "R7 no strobe at stop", {done, thr_clr}, 0);
        exp_clr = !alive ? 2'b00 : (ad == 8'h03 ? 2'b01 : 2'b10);
        pin_fall(alive, exp_clr, "R8 completion");
        chk(busy == 1'b0, "R8 idle after completion", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(busy == 0 && ack == 0 && done == 0 && thr_clr == 0, "R1 reset state",
            {busy, ack, done, thr_clr}, 0);

        // R3: sweep the device byte
        for (int v = 0; v < 256; v++) run_cmd(8'(v), 8'h03, 8'h00);
        // R4: sweep the selector byte
        for (int v = 0; v < 256; v++) run_cmd(8'hA0, 8'(v), 8'h00);
        // R5: sweep the data byte
        for (int v = 0; v < 256; v++) run_cmd(8'hA0, 8'h0B, 8'(v));

        // R2: voltage absent at start, then raised; nothing is armed
        do_start(1'b0);
        chk(busy == 0, "R2 busy after unarmed start", busy, 0);
        vp_present = 1'b1;
        send(8'hA0, 1'b0, "R2 device byte ignored");
        send(8'h03, 1'b0, "R2 selector byte ignored");
        send(8'h00, 1'b0, "R2 data byte ignored");
        do_stop();
        pin_fall(1'b0, 2'b00, "R2 no completion");

        // R6: ack lasts exactly one cycle
        do_start(1'b1);
        send(8'hA0, 1'b1, "R6 first ack");
        @(negedge clk);
        chk(ack == 0, "R6 ack one cycle", ack, 0);

        // R8: pin fall before the stop has no effect
        send(8'h0B, 1'b1, "R8 selector ack");
        pin_fall(1'b0, 2'b00, "R8 early fall ignored");
        chk(busy == 1, "R8 still busy after early fall", busy, 1);
        send(8'h00, 1'b1, "R8 data ack");
        do_stop();
        pin_fall(1'b1, 2'b10, "R8 late completion");

        // R9: fourth byte before stop
        do_start(1'b1);
        send(8'hA0, 1'b1, "R9 dev");
        send(8'h03, 1'b1, "R9 sel");
        send(8'h00, 1'b1, "R9 dat");
        send(8'h00, 1'b0, "R9 extra byte not acked");
        chk(busy == 0, "R9 idle after extra byte", busy, 0);
        do_stop();
        pin_fall(1'b0, 2'b00, "R9 no strobe after extra byte");

        // R9: stop after two bytes
        do_start(1'b1);
        send(8'hA0, 1'b1, "R9 dev");
        send(8'h03, 1'b1, "R9 sel");
        do_stop();
        chk(busy == 0, "R9 idle after early stop", busy, 0);
        pin_fall(1'b0, 2'b00, "R9 no strobe after early stop");

        // R10: armed start while waiting cancels
        do_start(1'b1);
        send(8'hA0, 1'b1, "R10 dev");
        send(8'h03, 1'b1, "R10 sel");
        send(8'h00, 1'b1, "R10 dat");
        do_stop();
        do_start(1'b1);
        chk(busy == 1, "R10 re-armed busy", busy, 1);
        pin_fall(1'b0, 2'b00, "R10 cancelled by armed start");
        do_stop();

        // R10: unarmed start while waiting cancels
        do_start(1'b1);
        send(8'hA0, 1'b1, "R10 dev");
        send(8'h0B, 1'b1, "R10 sel");
        send(8'h00, 1'b1, "R10 dat");
        do_stop();
        do_start(1'b0);
        chk(busy == 0, "R10 idle after unarmed start", busy, 0);
        pin_fall(1'b0, 2'b00, "R10 cancelled by unarmed start");

        // R11: strobe onehot on completion of threshold 0
        run_cmd(8'hA0, 8'h03, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule